// File: doc/BRIEF.md
# Dual-Channel Parallel Converter Register Front End

This block is the digital side of a two-channel 12-bit current-output converter. A host on a 12-bit parallel bus stores a code into a staging (input) register of either channel, and that code reaches the channel's output register (the one that sets the converter level) either right away or on a later update strobe. The host can also read back the output register of either channel over the same bus.

All control pins are asynchronous to the system clock. They pass through a two-flop synchronizer, and edges are detected on the synchronized copies. A write is committed when chip select goes back high. The update strobe works in one of two ways. If it is held low, every committed write also loads the output register. If it falls, both staging registers are copied into their output registers. A low clear input empties every register. The bidirectional bus is split into an input word, an output word and a drive enable, and a pad ring joins them.

Top module: `dac_bus_front`

## Requirements
- R1: After reset, both output codes are 0 and bus_drive is 0.
- R2: A write takes effect when cs_n rises while rd_wr_n is 0. The word on bus_din (bit 11 is the MSB) goes into the staging register of the channel named by chan_b (0 = A, 1 = B). The result shows on the ports within four clock edges of the rise.
- R3: Registers are not transparent. While cs_n is still low during a write, neither output code changes.
- R4: While upd_n is held high, a write changes no output code.
- R5: While upd_n is held low, a committed write also loads the selected channel's output register with the new word.
- R6: A falling edge on upd_n copies each channel's staging register into that channel's output register. No chip-select activity is needed.
- R7: If a write commit and an upd_n falling edge are detected in the same cycle, the selected channel's output register takes the newly written word.
- R8: When cs_n is low and rd_wr_n is 1, bus_drive is 1 and bus_dout carries the output register of the channel named by chan_b, not its staging register. A read changes no register.
- R9: At all other times bus_drive is 0 and bus_dout is 0.
- R10: While clr_n is low, all four registers are cleared to 0. Clear wins over a write commit or an update edge detected in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| chan_b | input | 1 | Channel select: 0 = A, 1 = B |
| upd_n | input | 1 | Update strobe, active low |
| clr_n | input | 1 | Clear, active low |
| bus_din | input | 12 | Data bus input word |
| bus_dout | output | 12 | Readback word |
| bus_drive | output | 1 | Drive enable for the bus pads |
| code_a | output | 12 | Channel A output register |
| code_b | output | 12 | Channel B output register |

## Verification
A write commit and an update falling edge can be detected in the same cycle. So can a write commit and a clear. The bench provokes each case by moving cs_n high and moving upd_n low (or clr_n low) on the same falling clock edge. Both pins pass through identical synchronizers, so the two events reach the registers in the same cycle. The bench then judges the outcome against its own model. For a coincident update, the selected channel shows the fresh word and the other channel shows its previously staged word. For a coincident clear, all codes read zero.

// File: rtl/dac_front_pkg.sv
package dac_front_pkg;
    localparam int CODE_W = 12;
    localparam int NUM_CH = 2;

    typedef logic [CODE_W-1:0] code_t;

    // bit positions inside the synchronized control vector
    localparam int PIN_CS  = 0;
    localparam int PIN_RW  = 1;
    localparam int PIN_UPD = 2;
    localparam int PIN_CLR = 3;
    localparam int NUM_PINS = 4;

    // idle levels: selects/strobes high, read/write low
    localparam logic [NUM_PINS-1:0] PIN_IDLE = 4'b1101;

    typedef struct packed {
        logic clr;
        logic wr_en;
        logic xfer;
    } chan_ctl_t;

    function automatic logic sel_match(input logic sel, input int idx);
        return (int'(sel) == idx);
    endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W = 4,
    parameter logic [W-1:0] IDLE = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins,
    output logic [W-1:0] level
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= IDLE;
            stab_q <= IDLE;
        end else begin
            meta_q <= pins;
            stab_q <= meta_q;
        end
    end

    assign level = stab_q;
endmodule

// File: rtl/edge_pick.sv
module edge_pick #(
    parameter bit RISING = 1'b1,
    parameter bit IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic pulse
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= IDLE;
        else     prev_q <= lvl;
    end

    generate
        if (RISING) begin : g_rise
            assign pulse = lvl & ~prev_q;
        end else begin : g_fall
            assign pulse = ~lvl & prev_q;
        end
    endgenerate

    // an edge pulse never lasts two cycles (supports R2/R6)
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse)
        else $error("edge pulse held two cycles");
endmodule

// File: rtl/chan_regs.sv
module chan_regs
    import dac_front_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  chan_ctl_t ctl,
    input  code_t     data,
    output code_t     dac_q
);
    code_t stage_q;
    code_t stage_nx;

    // a transfer in the same cycle as a write sees the new word (R7)
    always_comb begin
        stage_nx = ctl.wr_en ? data : stage_q;
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            stage_q <= '0;
            dac_q   <= '0;
        end else begin
            stage_q <= stage_nx;
            if (ctl.xfer) dac_q <= stage_nx;
        end
    end

    assert_clear_zero_R10: assert property (@(posedge clk) disable iff (rst)
        ctl.clr |=> (stage_q == '0 && dac_q == '0))
        else $error("clear did not empty channel");

    assert_write_stage_R2: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr && ctl.wr_en) |=> stage_q == $past(data))
        else $error("staging register missed write");

    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (!ctl.clr && !ctl.xfer) |=> $stable(dac_q))
        else $error("output register moved without transfer");
endmodule

// File: rtl/dac_bus_front.sv
module dac_bus_front
    import dac_front_pkg::*;
#(
    parameter int DW = CODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_wr_n,
    input  logic          chan_b,
    input  logic          upd_n,
    input  logic          clr_n,
    input  logic [DW-1:0] bus_din,
    output logic [DW-1:0] bus_dout,
    output logic          bus_drive,
    output logic [DW-1:0] code_a,
    output logic [DW-1:0] code_b
);
    logic [NUM_PINS-1:0] raw_pins;
    logic [NUM_PINS-1:0] lvl;
    logic                cs_rise;
    logic                upd_fall;
    logic                commit;
    code_t               dac_vals [NUM_CH];

    always_comb begin
        raw_pins          = '0;
        raw_pins[PIN_CS]  = cs_n;
        raw_pins[PIN_RW]  = rd_wr_n;
        raw_pins[PIN_UPD] = upd_n;
        raw_pins[PIN_CLR] = clr_n;
    end

    pin_sync #(.W(NUM_PINS), .IDLE(PIN_IDLE)) u_sync (
        .clk(clk), .rst(rst), .pins(raw_pins), .level(lvl)
    );

    edge_pick #(.RISING(1'b1), .IDLE(PIN_IDLE[PIN_CS])) u_cs_edge (
        .clk(clk), .rst(rst), .lvl(lvl[PIN_CS]), .pulse(cs_rise)
    );

    edge_pick #(.RISING(1'b0), .IDLE(PIN_IDLE[PIN_UPD])) u_upd_edge (
        .clk(clk), .rst(rst), .lvl(lvl[PIN_UPD]), .pulse(upd_fall)
    );

    assign commit = cs_rise & ~lvl[PIN_RW];

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            chan_ctl_t ctl;
            always_comb begin
                ctl.clr   = ~lvl[PIN_CLR];
                ctl.wr_en = commit & sel_match(chan_b, ch);
                ctl.xfer  = upd_fall | (ctl.wr_en & ~lvl[PIN_UPD]);
            end
            chan_regs u_chan (
                .clk(clk), .rst(rst), .ctl(ctl), .data(bus_din),
                .dac_q(dac_vals[ch])
            );
        end
    endgenerate

    assign code_a    = dac_vals[0];
    assign code_b    = dac_vals[1];
    assign bus_drive = ~lvl[PIN_CS] & lvl[PIN_RW];

    always_comb begin
        bus_dout = '0;
        if (bus_drive) bus_dout = chan_b ? dac_vals[1] : dac_vals[0];
    end

    assert_read_source_R8: assert property (@(posedge clk) disable iff (rst)
        bus_drive |-> (bus_dout == (chan_b ? code_b : code_a)))
        else $error("readback not from output register");

    assert_bus_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_drive |-> (bus_dout == '0))
        else $error("bus word while not driving");

    assert_no_write_on_read_R8: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && lvl[PIN_RW] && !upd_fall && lvl[PIN_CLR]) |=>
            ($stable(code_a) && $stable(code_b)))
        else $error("read end changed a register");
endmodule

// File: tb/dac_bus_front_test.sv
module dac_bus_front_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, rd_wr_n = 1'b0, chan_b = 1'b0, upd_n = 1'b1, clr_n = 1'b1;
    logic [11:0] bus_din = '0;
    logic [11:0] bus_dout, code_a, code_b;
    logic        bus_drive;

    int checks = 0;
    int errors = 0;
    logic [11:0] m_stage [2];
    logic [11:0] m_dac   [2];

    always #4 clk = ~clk;

    dac_bus_front uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_wr_n(rd_wr_n), .chan_b(chan_b),
        .upd_n(upd_n), .clr_n(clr_n), .bus_din(bus_din), .bus_dout(bus_dout),
        .bus_drive(bus_drive), .code_a(code_a), .code_b(code_b)
    );

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_codes(input string req);
        chk({req, " code_a"}, code_a, m_dac[0]);
        chk({req, " code_b"}, code_b, m_dac[1]);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic void m_write(input bit ch, input logic [11:0] d, input bit upd_low);
        m_stage[ch] = d;
        if (upd_low) m_dac[ch] = d;
    endfunction

    function automatic void m_xfer();
        m_dac[0] = m_stage[0];
        m_dac[1] = m_stage[1];
    endfunction

    function automatic void m_clear();
        for (int i = 0; i < 2; i++) begin
            m_stage[i] = '0;
            m_dac[i]   = '0;
        end
    endfunction

    task automatic do_write(input bit ch, input logic [11:0] d);
        rd_wr_n = 1'b0; chan_b = ch; bus_din = d; cs_n = 1'b0;
        settle();
        chk_codes("R3 cs low no change");
        cs_n = 1'b1;
        settle();
        m_write(ch, d, !upd_n);
        chk_codes(upd_n ? "R2/R4 write" : "R5 auto update");
    endtask

    task automatic do_read(input bit ch);
        rd_wr_n = 1'b1; chan_b = ch; cs_n = 1'b0;
        settle();
        chk("R8 drive", {11'b0, bus_drive}, 12'h001);
        chk("R8 readback", bus_dout, m_dac[ch]);
        cs_n = 1'b1;
        settle();
        chk("R9 released", {11'b0, bus_drive}, 12'h000);
        chk("R9 quiet", bus_dout, 12'h000);
        chk_codes("R8 read no change");
        rd_wr_n = 1'b0;
        settle();
    endtask

    task automatic set_upd(input bit v);
        bit was = upd_n;
        upd_n = v;
        settle();
        if (was && !v) m_xfer();
        chk_codes("R6 update edge");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [11:0] w;
        void'($urandom(32'd20240611));
        m_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_codes("R1 reset");
        chk("R1 drive", {11'b0, bus_drive}, 12'h000);

        // directed: extreme words, staged-only writes, then transfer
        do_write(1'b0, 12'hFFF);
        do_write(1'b1, 12'h800);
        do_read(1'b0);               // R8: output register still 0, not staged FFF
        set_upd(1'b0);               // R6
        set_upd(1'b1);
        do_read(1'b1);
        set_upd(1'b0);
        do_write(1'b1, 12'h001);     // R5
        do_write(1'b0, 12'h7FE);
        set_upd(1'b1);

        // R7: commit and update fall detected together
        do_write(1'b0, 12'h123);
        rd_wr_n = 1'b0; chan_b = 1'b1; bus_din = 12'hABC; cs_n = 1'b0;
        settle();
        cs_n = 1'b1; upd_n = 1'b0;
        settle();
        m_write(1'b1, 12'hABC, 1'b0);
        m_xfer();
        chk_codes("R7 coincident");
        set_upd(1'b1);

        // R10: clear together with a write commit
        rd_wr_n = 1'b0; chan_b = 1'b0; bus_din = 12'h555; cs_n = 1'b0;
        settle();
        cs_n = 1'b1; clr_n = 1'b0;
        settle();
        m_clear();
        chk_codes("R10 clear priority");
        clr_n = 1'b1;
        settle();
        set_upd(1'b0);
        chk_codes("R10 staging emptied");
        set_upd(1'b1);

        // random mix
        for (int n = 0; n < 80; n++) begin
            int op = $urandom % 5;
            w = 12'($urandom);
            case (op)
                0, 1: do_write(1'($urandom), w);
                2:    do_read(1'($urandom));
                3:    set_upd(~upd_n);
                default: begin
                    clr_n = 1'b0;
                    settle();
                    m_clear();
                    chk_codes("R10 clear");
                    clr_n = 1'b1;
                    settle();
                end
            endcase
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule